// File: doc/BRIEF.md
# Translation Buffer with Per-Entry Use Counters

This block is a small fully associative address-translation cache in which every entry keeps a counter of how many times the processor has used it since the entry was last written. Lookups return a physical page number in the same cycle. Refills come from an external page walker. Entries can be dropped one at a time by virtual page, all together on a context switch, or have only their counters zeroed by a coherency-control operation.

Usage data leaves the block by two routes. A sampling port lets software pick any slot and read its virtual page and counter. A report channel emits one record (processor ID, virtual page, counter) each time a valid entry is displaced by a refill or removed by an invalidation or a context-switch flush. The report channel uses a ready/valid handshake, and the block stalls its commands while a record is still waiting to be taken.

Top module: `tlb_access_count`

## Requirements
- R1: When `lk_valid` is high, outside a flush, and a valid entry holds `lk_vpn`, `lk_hit` is high in that same cycle and shows that entry's physical page and dirty bit. Otherwise `lk_hit` is low.
- R2: Each cycle with `lk_hit` high adds one to the counter of the entry that hit. The counter stops at 2^CNT_W-1 and does not wrap.
- R3: An accepted refill writes the victim entry with the new page, dirty bit and valid flag, and sets its counter to 0. The victim is the lowest-index invalid entry if one exists. When every entry is valid, the victim comes from a round-robin pointer that starts at index 0 after reset and advances by one only on that kind of eviction.
- R4: A refill that displaces a valid entry emits a report holding CPU_ID, the evicted virtual page and its counter as it stood before the refill edge.
- R5: An accepted invalidation whose page matches a valid entry clears that entry's valid flag and counter and emits a report for it. An invalidation that matches no entry changes nothing and emits no report.
- R6: A pulse on `coh_clr` zeroes every counter and leaves the translations valid. It wins over a hit increment in the same cycle.
- R7: An accepted `flush_req` raises `flush_busy`. The flush then visits the entries in ascending index order, and each valid entry gives one report and is invalidated. Lookups miss while the flush runs. `flush_busy` falls once the last index has been visited, and by then no entry is valid.
- R8: A pending report keeps its fields stable until `rpt_ready` is high. `cmd_ready` is high only when no flush is running and the report register is empty or being taken. Commands offered while `cmd_ready` is low are ignored.
- R9: In the same cycle, `smp_valid` shows whether slot `smp_idx` is valid. `smp_vpn` and `smp_cnt` show that slot's page and counter, and both read 0 when the slot is invalid.
- R10: The accepted commands have a fixed priority: invalidation first, then refill, then flush. A lookup that hits the entry being invalidated in the same cycle counts as a miss and does not increment the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page on hit |
| lk_dirty | output | 1 | Dirty bit on hit |
| fill_valid | input | 1 | Refill command |
| fill_vpn | input | VPN_W | Refill virtual page |
| fill_ppn | input | PPN_W | Refill physical page |
| fill_dirty | input | 1 | Refill dirty bit |
| inv_valid | input | 1 | Single-entry invalidation command |
| inv_vpn | input | VPN_W | Page to invalidate |
| flush_req | input | 1 | Context-switch flush command |
| coh_clr | input | 1 | Coherency-control counter clear |
| cmd_ready | output | 1 | Commands accepted this cycle |
| flush_busy | output | 1 | Flush in progress |
| smp_idx | input | IDX_W | Sampling slot select |
| smp_valid | output | 1 | Selected slot is valid |
| smp_vpn | output | VPN_W | Selected slot virtual page |
| smp_cnt | output | CNT_W | Selected slot counter |
| rpt_valid | output | 1 | Report record pending |
| rpt_ready | input | 1 | Report consumer ready |
| rpt_cpu | output | CPU_W | Report processor ID |
| rpt_vpn | output | VPN_W | Report virtual page |
| rpt_cnt | output | CNT_W | Report counter |

## Verification
The assertions assume that a refill never brings in a page that is already resident. If it did, a lookup could match two slots and the one-hot hit check would fail. The random stimulus respects this: the bench looks up each refill page in its own model and drops the refill if the page is already there. Pages come from a range of eight so that hits, invalidations that match, and evictions all occur often. `rpt_ready` is driven at random, so the stall and hold behaviour is exercised while commands keep arriving.

// File: rtl/tlbc_pkg.sv
// Shared types for the counted translation buffer.
// Assumes: nothing beyond IEEE 1800-2017 packed enums.
package tlbc_pkg;
    // Which event loads the report register this cycle
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_INV   = 2'd1,
        SRC_FILL  = 2'd2,
        SRC_FLUSH = 2'd3
    } rpt_src_e;
endpackage

// File: rtl/tlbc_entry.sv
// One translation slot: valid, dirty, pages and a saturating use counter.
// Assumes: at most one of load/kill is high per cycle; load > kill > clr > inc.
module tlbc_entry #(
    parameter int VPN_W = 8,
    parameter int PPN_W = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             kill,
    input  logic             clr,
    input  logic             inc,
    input  logic [VPN_W-1:0] ld_vpn,
    input  logic [PPN_W-1:0] ld_ppn,
    input  logic             ld_dirty,
    output logic             valid,
    output logic [VPN_W-1:0] vpn,
    output logic [PPN_W-1:0] ppn,
    output logic             dirty,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Slot state update with fixed command priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            vpn   <= '0;
            ppn   <= '0;
            dirty <= 1'b0;
            cnt   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            vpn   <= ld_vpn;
            ppn   <= ld_ppn;
            dirty <= ld_dirty;
            cnt   <= '0;
        end else if (kill) begin
            valid <= 1'b0;
            cnt   <= '0;
        end else if (clr) begin
            cnt   <= '0;
        end else if (inc && cnt != CNT_MAX) begin
            cnt   <= cnt + 1'b1;
        end
    end

    // R2
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && inc && !load && !kill && !clr) |=> (cnt == CNT_MAX));
    // R3
    load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (valid && cnt == '0));
    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !load) |=> (cnt == '0));
endmodule

// File: rtl/tlbc_victim.sv
// Refill victim picker: lowest invalid slot first, else round-robin pointer.
// Assumes: ENTRIES is a power of two; take is high only on an accepted refill.
module tlbc_victim #(
    parameter int ENTRIES = 4,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               take,
    output logic [IDX_W-1:0]   idx
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;

    // Search for the lowest-index invalid slot
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
        idx = free_found ? free_idx : rr_q;
    end

    // Advance the round-robin pointer only when a valid slot is displaced
    always_ff @(posedge clk) begin
        if (!rst_n)                    rr_q <= '0;
        else if (take && !free_found)  rr_q <= rr_q + 1'b1;
    end

    // R3
    free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(&valid_vec)) |-> !valid_vec[idx]);
endmodule

// File: rtl/tlb_access_count.sv
// Fully associative translation buffer whose slots count their own hits.
// Reports evicted/invalidated/flushed slots through a ready/valid channel and
// exposes any slot through a sampling port.
// Assumes: a refill never carries a page already resident; ENTRIES power of two.
module tlb_access_count
    import tlbc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 8,
    parameter int PPN_W   = 8,
    parameter int CNT_W   = 3,
    parameter int CPU_W   = 2,
    parameter logic [CPU_W-1:0] CPU_ID = 2'd1,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_dirty,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_dirty,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush_req,
    input  logic             coh_clr,
    output logic             cmd_ready,
    output logic             flush_busy,
    input  logic [IDX_W-1:0] smp_idx,
    output logic             smp_valid,
    output logic [VPN_W-1:0] smp_vpn,
    output logic [CNT_W-1:0] smp_cnt,
    output logic             rpt_valid,
    input  logic             rpt_ready,
    output logic [CPU_W-1:0] rpt_cpu,
    output logic [VPN_W-1:0] rpt_vpn,
    output logic [CNT_W-1:0] rpt_cnt
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] ev, ed, match_lk, match_inv, hit_vec, load_vec, kill_vec;
    logic [VPN_W-1:0]   ev_vpn [ENTRIES];
    logic [PPN_W-1:0]   ev_ppn [ENTRIES];
    logic [CNT_W-1:0]   ev_cnt [ENTRIES];

    logic             flushing, slot_free, inv_go, fill_go, flush_go, fl_emit, fl_adv;
    logic [IDX_W-1:0] fptr, vic_idx, inv_idx, src_idx;
    rpt_src_e         src;

    // Command acceptance and priority
    always_comb begin
        slot_free = !rpt_valid || rpt_ready;
        cmd_ready = !flushing && slot_free;
        inv_go    = inv_valid && cmd_ready;
        fill_go   = fill_valid && cmd_ready && !inv_valid;
        flush_go  = flush_req && cmd_ready && !inv_valid && !fill_valid;
        fl_emit   = flushing && ev[fptr] && slot_free;
        fl_adv    = flushing && (!ev[fptr] || slot_free);
    end

    // Per-slot match, hit, load and kill decisions
    always_comb begin
        inv_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            match_lk[i]  = ev[i] && (ev_vpn[i] == lk_vpn);
            match_inv[i] = ev[i] && (ev_vpn[i] == inv_vpn);
            hit_vec[i]   = lk_valid && !flushing && match_lk[i] && !(inv_go && match_inv[i]);
            load_vec[i]  = fill_go && (vic_idx == IDX_W'(i));
            kill_vec[i]  = (inv_go && match_inv[i]) || (fl_emit && fptr == IDX_W'(i));
            if (match_inv[i]) inv_idx = IDX_W'(i);
        end
    end

    // Lookup result mux
    always_comb begin
        lk_hit   = |hit_vec;
        lk_ppn   = '0;
        lk_dirty = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                lk_ppn   = ev_ppn[i];
                lk_dirty = ed[i];
            end
        end
    end

    // Translation slots
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        tlbc_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W), .CNT_W(CNT_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .load(load_vec[g]), .kill(kill_vec[g]), .clr(coh_clr), .inc(hit_vec[g]),
            .ld_vpn(fill_vpn), .ld_ppn(fill_ppn), .ld_dirty(fill_dirty),
            .valid(ev[g]), .vpn(ev_vpn[g]), .ppn(ev_ppn[g]), .dirty(ed[g]), .cnt(ev_cnt[g])
        );
    end

    // Refill victim selection
    tlbc_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid_vec(ev), .take(fill_go), .idx(vic_idx)
    );

    // Pick which event, if any, writes the report register
    always_comb begin
        src     = SRC_NONE;
        src_idx = '0;
        if (fl_emit) begin
            src = SRC_FLUSH; src_idx = fptr;
        end else if (inv_go && |match_inv) begin
            src = SRC_INV;   src_idx = inv_idx;
        end else if (fill_go && ev[vic_idx]) begin
            src = SRC_FILL;  src_idx = vic_idx;
        end
    end

    // Report register with ready/valid hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_valid <= 1'b0;
            rpt_vpn   <= '0;
            rpt_cnt   <= '0;
        end else if (src != SRC_NONE) begin
            rpt_valid <= 1'b1;
            rpt_vpn   <= ev_vpn[src_idx];
            rpt_cnt   <= ev_cnt[src_idx];
        end else if (rpt_ready) begin
            rpt_valid <= 1'b0;
        end
    end
    assign rpt_cpu = CPU_ID;

    // Context-switch flush sequencer walking slots in index order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flushing <= 1'b0;
            fptr     <= '0;
        end else if (flush_go) begin
            flushing <= 1'b1;
            fptr     <= '0;
        end else if (fl_adv) begin
            if (fptr == LAST_IDX) flushing <= 1'b0;
            else                  fptr     <= fptr + 1'b1;
        end
    end
    assign flush_busy = flushing;

    // Sampling port
    always_comb begin
        smp_valid = ev[smp_idx];
        smp_vpn   = smp_valid ? ev_vpn[smp_idx] : '0;
        smp_cnt   = smp_valid ? ev_cnt[smp_idx] : '0;
    end

    // R1
    hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_lk));
    // R8
    rpt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable(rpt_vpn) && $stable(rpt_cnt)));
    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_busy) |-> (ev == '0));
    // R7
    flush_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |-> !lk_hit);
endmodule

// File: tb/tlb_access_count_test.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared every cycle against a behavioural model built from the requirements.
module tlb_access_count_test;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lk_valid = 0, fill_valid = 0, fill_dirty = 0, inv_valid = 0;
    logic       flush_req = 0, coh_clr = 0, rpt_ready = 0;
    logic [7:0] lk_vpn = 0, fill_vpn = 0, fill_ppn = 0, inv_vpn = 0;
    logic [1:0] smp_idx = 0;
    logic       lk_hit, lk_dirty, cmd_ready, flush_busy, smp_valid, rpt_valid;
    logic [7:0] lk_ppn, smp_vpn, rpt_vpn;
    logic [2:0] smp_cnt, rpt_cnt;
    logic [1:0] rpt_cpu;

    int compared = 0, mismatched = 0;
    bit done = 0;

    // model state
    bit       m_v[N];  logic [7:0] m_vpn[N], m_ppn[N]; bit m_d[N]; int m_cnt[N];
    int       m_rr = 0, m_fp = 0; bit m_fl = 0, m_rv = 0; logic [7:0] m_rvpn = 0; int m_rcnt = 0;

    tlb_access_count uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
        .lk_ppn(lk_ppn), .lk_dirty(lk_dirty), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_dirty(fill_dirty), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
        .flush_req(flush_req), .coh_clr(coh_clr), .cmd_ready(cmd_ready), .flush_busy(flush_busy),
        .smp_idx(smp_idx), .smp_valid(smp_valid), .smp_vpn(smp_vpn), .smp_cnt(smp_cnt),
        .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_cpu(rpt_cpu), .rpt_vpn(rpt_vpn),
        .rpt_cnt(rpt_cnt)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int find(input logic [7:0] v);
        for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    function automatic int sat_inc(input int c);
        return (c == 7) ? 7 : c + 1;
    endfunction

    // One clock: compare outputs with the model, then advance the model at the edge
    task automatic cycle();
        bit slot, cr, ig, fg, flg, ehit, femit, fadv;
        int hi, ii, vic, free, sidx;
        bit n_v[N]; logic [7:0] n_vpn[N], n_ppn[N]; bit n_d[N]; int n_cnt[N];
        #1;
        slot = !m_rv || rpt_ready;
        cr   = !m_fl && slot;
        ig   = inv_valid && cr;
        fg   = fill_valid && cr && !inv_valid;
        flg  = flush_req && cr && !inv_valid && !fill_valid;
        hi   = find(lk_vpn);
        ii   = find(inv_vpn);
        ehit = lk_valid && !m_fl && hi >= 0 && !(ig && ii == hi);
        chk(cmd_ready == cr, "R8", "cmd_ready", cmd_ready, cr);
        chk(flush_busy == m_fl, "R7", "flush_busy", flush_busy, m_fl);
        chk(lk_hit == ehit, "R1_R10", "lk_hit", lk_hit, ehit);
        if (ehit) begin
            chk(lk_ppn == m_ppn[hi], "R1", "lk_ppn", lk_ppn, m_ppn[hi]);
            chk(lk_dirty == m_d[hi], "R1", "lk_dirty", lk_dirty, m_d[hi]);
        end
        chk(rpt_valid == m_rv, "R8", "rpt_valid", rpt_valid, m_rv);
        if (m_rv) begin
            chk(rpt_vpn == m_rvpn, "R4_R5_R7", "rpt_vpn", rpt_vpn, m_rvpn);
            chk(int'(rpt_cnt) == m_rcnt, "R4_R5_R7", "rpt_cnt", rpt_cnt, m_rcnt);
            chk(rpt_cpu == 2'd1, "R4", "rpt_cpu", rpt_cpu, 1);
        end
        chk(smp_valid == m_v[smp_idx], "R9", "smp_valid", smp_valid, m_v[smp_idx]);
        chk(smp_vpn == (m_v[smp_idx] ? m_vpn[smp_idx] : 8'd0), "R9", "smp_vpn", smp_vpn,
            m_v[smp_idx] ? m_vpn[smp_idx] : 0);
        chk(int'(smp_cnt) == (m_v[smp_idx] ? m_cnt[smp_idx] : 0), "R9_R2", "smp_cnt", smp_cnt,
            m_v[smp_idx] ? m_cnt[smp_idx] : 0);
        // next state
        n_v = m_v; n_vpn = m_vpn; n_ppn = m_ppn; n_d = m_d; n_cnt = m_cnt;
        free = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) free = i;
        vic   = (free >= 0) ? free : m_rr;
        femit = m_fl && m_v[m_fp] && slot;
        fadv  = m_fl && (!m_v[m_fp] || slot);
        sidx  = -1;
        if (femit) sidx = m_fp;
        else if (ig && ii >= 0) sidx = ii;
        else if (fg && m_v[vic]) sidx = vic;
        for (int i = 0; i < N; i++) begin
            if (ehit && hi == i) n_cnt[i] = sat_inc(m_cnt[i]);
            if (coh_clr) n_cnt[i] = 0;
        end
        if (femit) begin n_v[m_fp] = 0; n_cnt[m_fp] = 0; end
        if (ig && ii >= 0) begin n_v[ii] = 0; n_cnt[ii] = 0; end
        if (fg) begin
            n_v[vic] = 1; n_vpn[vic] = fill_vpn; n_ppn[vic] = fill_ppn;
            n_d[vic] = fill_dirty; n_cnt[vic] = 0;
        end
        @(posedge clk);
        if (sidx >= 0) begin m_rv = 1; m_rvpn = m_vpn[sidx]; m_rcnt = m_cnt[sidx]; end
        else if (rpt_ready) m_rv = 0;
        if (fg && free < 0) m_rr = (m_rr + 1) % N;
        if (flg) begin m_fl = 1; m_fp = 0; end
        else if (fadv) begin
            if (m_fp == N - 1) m_fl = 0; else m_fp++;
        end
        m_v = n_v; m_vpn = n_vpn; m_ppn = n_ppn; m_d = n_d; m_cnt = n_cnt;
        @(negedge clk);
    endtask

    task automatic idle();
        lk_valid = 0; fill_valid = 0; inv_valid = 0; flush_req = 0; coh_clr = 0;
    endtask

    // Watchdog
    initial begin
        #2000000;
        if (!done) begin
            mismatched++; compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_d[i] = 0; m_cnt[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state (R8, R9)
        rpt_ready = 1;
        for (int s = 0; s < N; s++) begin smp_idx = 2'(s); cycle(); end

        // R3: fill slots 0..3 from empty, then R2 saturation on page 3
        for (int k = 0; k < N; k++) begin
            idle(); fill_valid = 1; fill_vpn = 8'(k + 1); fill_ppn = 8'(8'h40 + k); fill_dirty = k[0];
            smp_idx = 2'(k); cycle();
        end
        idle(); smp_idx = 2;
        for (int k = 0; k < 10; k++) begin lk_valid = 1; lk_vpn = 8'd3; cycle(); end
        idle(); cycle();
        chk(smp_cnt == 3'd7, "R2", "saturated count", smp_cnt, 7);

        // R4: full buffer, round-robin evicts slot 0 (page 1, count 0)
        idle(); fill_valid = 1; fill_vpn = 8'd9; fill_ppn = 8'h99; cycle();
        idle(); cycle();
        // R10: hit and invalidate page 3 in one cycle -> miss, report count 7
        lk_valid = 1; lk_vpn = 8'd3; inv_valid = 1; inv_vpn = 8'd3; #1;
        chk(lk_hit == 1'b0, "R10", "hit during invalidate", lk_hit, 0);
        cycle();
        idle(); #1;
        chk(rpt_vpn == 8'd3 && rpt_cnt == 3'd7, "R5", "invalidate report count", rpt_cnt, 7);
        cycle();
        // R6: counter clear beats hit
        lk_valid = 1; lk_vpn = 8'd9; coh_clr = 1; smp_idx = 0; cycle();
        idle(); cycle();
        chk(smp_cnt == 3'd0 && smp_valid, "R6", "count after clear", smp_cnt, 0);
        // R7: flush with back-pressure
        rpt_ready = 0; flush_req = 1; cycle();
        idle();
        for (int k = 0; k < 12; k++) begin rpt_ready = k[0]; lk_valid = 1; lk_vpn = 8'd9; cycle(); end
        rpt_ready = 1; idle(); cycle(); cycle();

        // Random traffic
        for (int t = 0; t < 4000; t++) begin
            lk_valid   = ($urandom % 10) < 7;
            lk_vpn     = 8'($urandom % 8);
            fill_valid = ($urandom % 4) == 0;
            fill_vpn   = 8'($urandom % 8);
            fill_ppn   = 8'($urandom);
            fill_dirty = 1'($urandom);
            if (find(fill_vpn) >= 0) fill_valid = 0;
            inv_valid  = ($urandom % 10) == 0;
            inv_vpn    = 8'($urandom % 8);
            flush_req  = ($urandom % 60) == 0;
            coh_clr    = ($urandom % 40) == 0;
            rpt_ready  = ($urandom % 10) < 7;
            smp_idx    = 2'($urandom);
            cycle();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule